// File: doc/BRIEF.md
# Address Aperture Decoder with Protected Low Load Range

This block classifies every 32-bit data access into one of four targets: a small protected range at the bottom of the address space, a DRAM window, a 2 MB window of memory-mapped registers, or the external PCI bus. A load that lands in the protected range while it is active gets a forced zero result and no external access. A store to the same addresses takes the ordinary aperture routing. This keeps speculative loads of near-null pointers off the slow external bus.

The DRAM base, the inclusive DRAM limit, the register-window base and a range-enable bit are written through a small configuration port. The decode is registered. A request presented with `reqValid` produces a one-hot target and a zero-result flag, both qualified by `rspValid`, one clock later. Bus protocols and the memories behind each target are outside this block.

Top module: `aperture_router`

## Requirements
- R1: After reset, `rspValid`, `rspTarget`, `rspZeroLoad` and `cfgAlignErr` are 0. The protected range is enabled, the DRAM window is 0x1000_0000..0x10FF_FFFF and the register window base is 0x2000_0000.
- R2: A request with `reqValid` high at a clock edge yields `rspValid`=1 at the next edge, with exactly one `rspTarget` bit set (bit0 protected range, bit1 DRAM, bit2 registers, bit3 PCI). Without a request, `rspValid`, `rspTarget` and `rspZeroLoad` are all 0.
- R3: A load (`reqIsLoad`=1) to an address 0x00..0xFF, with the range enabled and not overlapped by DRAM, selects bit0 and sets `rspZeroLoad`=1. No other response sets `rspZeroLoad`.
- R4: A store to 0x00..0xFF never selects bit0. It is routed by the DRAM, register and PCI rules.
- R5: Configuration write `cfgSel`=3 sets the range enable from `cfgWrData[0]`. While it is 0, loads to 0x00..0xFF are routed like stores.
- R6: When the DRAM window is non-empty (limit >= base) and its base is <= 0xFF, the protected range is ignored for every address.
- R7: An address hits DRAM when base <= addr <= limit (limit inclusive) and addr - base < 64 MB. `cfgSel`=0 writes the base and `cfgSel`=1 writes the limit.
- R8: `cfgSel`=2 writes the register window base, stored aligned down to 2 MB. An address hits the register window when its bits [31:21] equal those of the base.
- R9: A register-base write with any of `cfgWrData[20:0]` nonzero sets `cfgAlignErr` from the next cycle. An aligned register-base write clears it.
- R10: An address in both DRAM and the register window selects DRAM.
- R11: An address matching no other target selects PCI (bit3).
- R12: A configuration write takes effect for requests in the following cycle. A request in the same cycle as the write uses the previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request valid |
| reqAddr | input | 32 | Access byte address |
| reqIsLoad | input | 1 | 1 = load, 0 = store |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | 0 DRAM base, 1 DRAM limit, 2 register base, 3 control |
| cfgWrData | input | 32 | Configuration write data |
| rspValid | output | 1 | Decode result valid |
| rspTarget | output | 4 | One-hot target: bit0 range, bit1 DRAM, bit2 registers, bit3 PCI |
| rspZeroLoad | output | 1 | Force the load result to zero |
| cfgAlignErr | output | 1 | Last register-base write was not 2 MB aligned |

## Verification
The bench sweeps every address of the low 260 bytes as both load and store across four configurations. It also probes both sides of each window edge: DRAM base and limit, the 64 MB size cap, and the register window edges. A design that compared the limit exclusively would send the last DRAM byte to PCI. A design that ignored the size cap would claim addresses beyond 64 MB for DRAM. A design that applied the protected range to stores, or kept it while DRAM covered address zero, would return zeros and block writes that should reach memory. Further checks cover a register window placed over DRAM, which must lose to DRAM; a misaligned register base, which must flag an error and still decode on 2 MB boundaries; and a control write in the same cycle as a request, which must not affect that request.

// File: rtl/aperture_pkg.sv
package aperture_pkg;
  localparam int unsigned NUM_TARGETS = 4;
  localparam int unsigned TGT_HOLE = 0;
  localparam int unsigned TGT_DRAM = 1;
  localparam int unsigned TGT_REGS = 2;
  localparam int unsigned TGT_PCI  = 3;

  localparam logic [1:0] SEL_DRAM_BASE  = 2'd0;
  localparam logic [1:0] SEL_DRAM_LIMIT = 2'd1;
  localparam logic [1:0] SEL_REG_BASE   = 2'd2;
  localparam logic [1:0] SEL_CONTROL    = 2'd3;

  typedef struct packed {
    logic wrDramBase;
    logic wrDramLimit;
    logic wrRegBase;
    logic capture;
  } strobes_t;
endpackage

// File: rtl/aperture_ctrl.sv
module aperture_ctrl
  import aperture_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned REG_AP_BITS = 21
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgWrData,
  output strobes_t          strobes,
  output logic              holeEn,
  output logic              rspValid,
  output logic              alignErr
);
  logic misaligned;

  assign misaligned = |cfgWrData[REG_AP_BITS-1:0];

  always_comb begin
    strobes             = '0;
    strobes.capture     = reqValid;
    strobes.wrDramBase  = cfgWrEn && (cfgSel == SEL_DRAM_BASE);
    strobes.wrDramLimit = cfgWrEn && (cfgSel == SEL_DRAM_LIMIT);
    strobes.wrRegBase   = cfgWrEn && (cfgSel == SEL_REG_BASE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holeEn   <= 1'b1;
      rspValid <= 1'b0;
      alignErr <= 1'b0;
    end else begin
      rspValid <= reqValid;
      if (cfgWrEn && (cfgSel == SEL_CONTROL)) holeEn <= cfgWrData[0];
      if (strobes.wrRegBase) alignErr <= misaligned;
    end
  end
endmodule

// File: rtl/aperture_datapath.sv
module aperture_datapath
  import aperture_pkg::*;
#(
  parameter int unsigned    ADDR_W        = 32,
  parameter int unsigned    HOLE_BITS     = 8,
  parameter int unsigned    REG_AP_BITS   = 21,
  parameter int unsigned    DRAM_MAX_BITS = 26,
  parameter logic [ADDR_W-1:0] RST_DRAM_BASE  = 32'h1000_0000,
  parameter logic [ADDR_W-1:0] RST_DRAM_LIMIT = 32'h10FF_FFFF,
  parameter logic [ADDR_W-1:0] RST_REG_BASE   = 32'h2000_0000
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobes_t               strobes,
  input  logic [ADDR_W-1:0]      cfgWrData,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic                   reqIsLoad,
  input  logic                   holeEn,
  output logic [NUM_TARGETS-1:0] rspTarget,
  output logic                   rspZeroLoad
);
  localparam int unsigned REG_TAG_W = ADDR_W - REG_AP_BITS;

  logic [ADDR_W-1:0]      dramBase, dramLimit, dramOffset;
  logic [REG_TAG_W-1:0]   regTag;
  logic                   dramOn, dramHit, regHit, holeHit, holeOverlap;
  logic [NUM_TARGETS-1:0] hits, pick;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dramBase  <= RST_DRAM_BASE;
      dramLimit <= RST_DRAM_LIMIT;
      regTag    <= RST_REG_BASE[ADDR_W-1:REG_AP_BITS];
    end else begin
      if (strobes.wrDramBase)  dramBase  <= cfgWrData;
      if (strobes.wrDramLimit) dramLimit <= cfgWrData;
      if (strobes.wrRegBase)   regTag    <= cfgWrData[ADDR_W-1:REG_AP_BITS];
    end
  end

  assign dramOn      = dramLimit >= dramBase;
  assign dramOffset  = reqAddr - dramBase;
  assign dramHit     = dramOn && (reqAddr >= dramBase) && (reqAddr <= dramLimit)
                       && (dramOffset[ADDR_W-1:DRAM_MAX_BITS] == '0);
  assign holeOverlap = dramOn && (dramBase[ADDR_W-1:HOLE_BITS] == '0);
  assign holeHit     = reqIsLoad && holeEn && !holeOverlap
                       && (reqAddr[ADDR_W-1:HOLE_BITS] == '0);
  assign regHit      = reqAddr[ADDR_W-1:REG_AP_BITS] == regTag;

  always_comb begin
    hits           = '0;
    hits[TGT_HOLE] = holeHit;
    hits[TGT_DRAM] = dramHit;
    hits[TGT_REGS] = regHit;
    hits[TGT_PCI]  = 1'b1;
  end

  // fixed priority: lower index wins
  generate
    for (genvar i = 0; i < NUM_TARGETS; i++) begin : g_prio
      if (i == 0) begin : g_first
        assign pick[i] = hits[i];
      end else begin : g_rest
        assign pick[i] = hits[i] && (hits[i-1:0] == '0);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspTarget   <= '0;
      rspZeroLoad <= 1'b0;
    end else if (strobes.capture) begin
      rspTarget   <= pick;
      rspZeroLoad <= pick[TGT_HOLE];
    end else begin
      rspTarget   <= '0;
      rspZeroLoad <= 1'b0;
    end
  end
endmodule

// File: rtl/aperture_router.sv
module aperture_router
  import aperture_pkg::*;
#(
  parameter int unsigned ADDR_W        = 32,
  parameter int unsigned HOLE_BITS     = 8,
  parameter int unsigned REG_AP_BITS   = 21,
  parameter int unsigned DRAM_MAX_BITS = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqIsLoad,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgWrData,
  output logic              rspValid,
  output logic [3:0]        rspTarget,
  output logic              rspZeroLoad,
  output logic              cfgAlignErr
);
  strobes_t strobes;
  logic     holeEn;

  aperture_ctrl #(.ADDR_W(ADDR_W), .REG_AP_BITS(REG_AP_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .cfgWrEn(cfgWrEn),
    .cfgSel(cfgSel), .cfgWrData(cfgWrData), .strobes(strobes),
    .holeEn(holeEn), .rspValid(rspValid), .alignErr(cfgAlignErr)
  );

  aperture_datapath #(
    .ADDR_W(ADDR_W), .HOLE_BITS(HOLE_BITS), .REG_AP_BITS(REG_AP_BITS),
    .DRAM_MAX_BITS(DRAM_MAX_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cfgWrData(cfgWrData),
    .reqAddr(reqAddr), .reqIsLoad(reqIsLoad), .holeEn(holeEn),
    .rspTarget(rspTarget), .rspZeroLoad(rspZeroLoad)
  );
endmodule

// File: rtl/aperture_router_chk.sv
module aperture_router_chk #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned HOLE_BITS   = 8,
  parameter int unsigned REG_AP_BITS = 21
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqIsLoad,
  input logic              cfgWrEn,
  input logic [1:0]        cfgSel,
  input logic [ADDR_W-1:0] cfgWrData,
  input logic              rspValid,
  input logic [3:0]        rspTarget,
  input logic              rspZeroLoad,
  input logic              cfgAlignErr
);
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && rspTarget == 4'b0 && !rspZeroLoad));
  p_one_target_r2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ($countones(rspTarget) == 1));
  p_zero_means_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    rspZeroLoad |-> rspTarget[0]);
  p_range_low_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (!reqIsLoad || reqAddr[ADDR_W-1:HOLE_BITS] != '0)) |=> !rspTarget[0]);
  p_align_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgSel == 2'd2) |=> (cfgAlignErr == $past(|cfgWrData[REG_AP_BITS-1:0])));
endmodule

bind aperture_router aperture_router_chk #(
  .ADDR_W(ADDR_W), .HOLE_BITS(HOLE_BITS), .REG_AP_BITS(REG_AP_BITS)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
  .reqIsLoad(reqIsLoad), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
  .cfgWrData(cfgWrData), .rspValid(rspValid), .rspTarget(rspTarget),
  .rspZeroLoad(rspZeroLoad), .cfgAlignErr(cfgAlignErr)
);

// File: tb/aperture_router_tb.sv
module aperture_router_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqIsLoad = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [31:0] cfgWrData = '0;
  logic        rspValid, rspZeroLoad, cfgAlignErr;
  logic [3:0]  rspTarget;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] mDramBase = 32'h1000_0000;
  logic [31:0] mDramLimit = 32'h10FF_FFFF;
  logic [31:0] mRegBase = 32'h2000_0000;
  logic        mHoleEn = 1'b1;

  always #10 clk = ~clk;

  aperture_router u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqIsLoad(reqIsLoad), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgWrData(cfgWrData), .rspValid(rspValid), .rspTarget(rspTarget),
    .rspZeroLoad(rspZeroLoad), .cfgAlignErr(cfgAlignErr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] model(input logic [31:0] a, input logic ld);
    logic on, dHit, ov, hHit, rHit;
    on   = mDramLimit >= mDramBase;
    dHit = on && a >= mDramBase && a <= mDramLimit && (a - mDramBase) < 32'h0400_0000;
    ov   = on && mDramBase <= 32'hFF;
    hHit = ld && mHoleEn && !ov && a <= 32'hFF;
    rHit = (a >> 21) == (mRegBase >> 21);
    if (hHit) return 4'b0001;
    if (dHit) return 4'b0010;
    if (rHit) return 4'b0100;
    return 4'b1000;
  endfunction

  task automatic cfgWrite(input logic [1:0] sel, input logic [31:0] d);
    cfgWrEn = 1'b1; cfgSel = sel; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    case (sel)
      2'd0: mDramBase = d;
      2'd1: mDramLimit = d;
      2'd2: mRegBase = d;
      default: mHoleEn = d[0];
    endcase
  endtask

  task automatic probe(input string tag, input logic [31:0] a, input logic ld);
    logic [3:0] e;
    e = model(a, ld);
    reqValid = 1'b1; reqAddr = a; reqIsLoad = ld;
    @(negedge clk);
    reqValid = 1'b0;
    check({tag, " valid"}, {31'b0, rspValid}, 32'd1);
    check({tag, " target"}, {28'b0, rspTarget}, {28'b0, e});
    check({tag, " zero"}, {31'b0, rspZeroLoad}, {31'b0, e == 4'b0001});
  endtask

  task automatic sweep(input string tag);
    for (int a = 0; a < 260; a++) begin
      probe({tag, " R3 R4 low load"}, 32'(a), 1'b1);
      probe({tag, " R4 low store"}, 32'(a), 1'b0);
    end
    probe({tag, " R7 dram base-1"}, mDramBase - 1, 1'b0);
    probe({tag, " R7 dram base"}, mDramBase, 1'b1);
    probe({tag, " R7 dram limit"}, mDramLimit, 1'b0);
    probe({tag, " R7 dram limit+1"}, mDramLimit + 1, 1'b1);
    probe({tag, " R7 cap-1"}, mDramBase + 32'h03FF_FFFF, 1'b0);
    probe({tag, " R7 cap"}, mDramBase + 32'h0400_0000, 1'b1);
    probe({tag, " R8 reg-1"}, {mRegBase[31:21], 21'h0} - 1, 1'b0);
    probe({tag, " R8 reg lo"}, {mRegBase[31:21], 21'h0}, 1'b1);
    probe({tag, " R8 reg hi"}, {mRegBase[31:21], 21'h1F_FFFF}, 1'b0);
    probe({tag, " R8 reg+2MB"}, {mRegBase[31:21], 21'h0} + 32'h0020_0000, 1'b1);
    probe({tag, " R11 top"}, 32'hFFFF_FFFF, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {31'b0, rspValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 valid", {31'b0, rspValid}, 32'd0);
    check("R1 target", {28'b0, rspTarget}, 32'd0);
    check("R1 zero", {31'b0, rspZeroLoad}, 32'd0);
    check("R1 alignErr", {31'b0, cfgAlignErr}, 32'd0);
    probe("R1 R3 default range", 32'h10, 1'b1);
    probe("R1 default dram", 32'h10FF_FFFF, 1'b1);
    probe("R1 default regs", 32'h2000_0040, 1'b1);
    @(negedge clk);
    check("R2 idle valid", {31'b0, rspValid}, 32'd0);
    check("R2 idle target", {28'b0, rspTarget}, 32'd0);

    sweep("cfg0");

    cfgWrite(2'd3, 32'h0);
    sweep("cfg1 R5 range off");
    cfgWrite(2'd3, 32'h1);

    // DRAM covers address zero; register window placed inside DRAM, misaligned
    cfgWrite(2'd0, 32'h0);
    cfgWrite(2'd1, 32'h00FF_FFFF);
    cfgWrite(2'd2, 32'h0040_1234);
    check("R9 misaligned flag", {31'b0, cfgAlignErr}, 32'd1);
    probe("R10 dram over regs", 32'h0040_0000, 1'b0);
    sweep("cfg2 R6 R10");
    cfgWrite(2'd2, 32'h0600_0000);
    check("R9 aligned clears", {31'b0, cfgAlignErr}, 32'd0);

    // DRAM limit far beyond 64 MB, register window over the low range
    cfgWrite(2'd0, 32'h0400_0000);
    cfgWrite(2'd1, 32'hFFFF_FFFF);
    cfgWrite(2'd2, 32'h0000_0000);
    sweep("cfg3 R7 cap R8");
    probe("R11 above cap", 32'h0900_0000, 1'b0);

    // R12: write and request in the same cycle
    cfgWrEn = 1'b1; cfgSel = 2'd3; cfgWrData = 32'h0;
    reqValid = 1'b1; reqAddr = 32'h20; reqIsLoad = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
    check("R12 same-cycle uses old", {28'b0, rspTarget}, 32'h1);
    @(negedge clk);
    reqValid = 1'b0;
    check("R12 next cycle uses new", {28'b0, rspTarget}, 32'h4);
    mHoleEn = 1'b0;
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule